// File: doc/BRIEF.md
# Serial Debug Access Frame Engine

This block sits behind a JTAG TAP controller. It turns one serial data frame into a single access in the system clock domain. The access goes to one of three targets: a small bank of debug configuration registers, a processor special-register port, or a single Wishbone transfer. The TAP supplies its capture, shift and update strobes on the test clock. The frame is assembled bit by bit from `tdi`, and an 8-bit check code protects it.

An update that arrives with the correct length and a matching check code toggles a request flag. That flag crosses into the system clock through a two-flop synchroniser. There an access state machine runs the transfer and stores a 34-bit return word. A completion toggle crosses back the same way.

Read results are not returned in the frame that asks for them. The return word is loaded into the output shifter at the next capture and appears on `tdo` during the frame that follows.

The access machine has six states:
- `S_IDLE` waits for a new request.
- `S_REG` does the register-bank access in one cycle.
- `S_CPU` drives the processor strobe for one cycle.
- `S_CPU_CAP` samples processor read data.
- `S_BUS` holds the Wishbone cycle until the slave answers.
- `S_DONE` flips the completion toggle.

The transitions are:
- From `S_IDLE`, a request goes to `S_REG`, `S_CPU` or `S_BUS` by chain.
- `S_REG` goes to `S_DONE`.
- `S_CPU` goes to `S_DONE` for a write and to `S_CPU_CAP` for a read.
- `S_CPU_CAP` goes to `S_DONE`.
- `S_BUS` stays put until ack or err, then goes to `S_DONE`.
- `S_DONE` goes to `S_IDLE`.

Top module: `jdf_top`

## Requirements
- R1: `chain_sel` picks the target: 0 is the register bank, 1 is the processor port and 2 is the bus. Code 3 launches nothing. The frame is shifted LSB first in this order: the address (5 bits for chain 0, 32 bits otherwise), then the direction bit (1 means write), then 32 data bits, then 8 check bits. The check code is a CRC-8 with polynomial 0x07 and initial value 0, taken over the address, direction and data bits in shift order; each step computes fb = crc[7]^bit, shifts crc left by one and XORs in 0x07 when fb is 1. An access is launched only by an update strobe.
- R2: Each completed access sets the return word. Bits 31:0 hold data, bit 32 is the bus-error flag and bit 33 is the bad-address flag. Writes return data 0. The word is shifted out on `tdo`, bit 0 first, during the frame after the access. After reset it is all zero.
- R3: The bank has five 32-bit registers at addresses 0 to 4. All reset to 0. Register n appears on `cfg_regs[32n+31:32n]`, and a write to address n changes only that slice.
- R4: An access to register address 5 through 31 changes no register. It returns data 0 with bit 33 set and bit 32 clear.
- R5: A frame whose received check code differs from the computed one launches no access of any kind, and the return word stays as it was.
- R6: A frame of any length other than exactly address + 41 bits launches no access.
- R7: A bus access holds `wb_cyc` and `wb_stb` high, with `wb_sel` at all ones and `wb_we`, `wb_adr` and `wb_dato` stable, through any number of wait states. It releases in the cycle after `wb_ack` or `wb_err`.
- R8: A bus read returns the `wb_dati` value present with `wb_ack`.
- R9: A bus access ended by `wb_err` returns bit 32 set, bit 33 clear and data 0.
- R10: A processor access drives `cpu_stb` for exactly one cycle, with `cpu_we` high for a write. A read returns the `cpu_rdata` value present one cycle after the strobe cycle. The processor strobe and the bus cycle are never active together.
- R11: The data bits of a read frame are ignored: a register read writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test-domain reset, active low |
| capture_dr | input | 1 | TAP capture strobe |
| shift_dr | input | 1 | TAP shift strobe |
| update_dr | input | 1 | TAP update strobe |
| tdi | input | 1 | Serial data in |
| chain_sel | input | 2 | Selected chain code |
| tdo | output | 1 | Serial data out |
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | System-domain reset, active low |
| wb_cyc | output | 1 | Bus cycle |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Bus write enable |
| wb_sel | output | 4 | Bus byte selects |
| wb_adr | output | 32 | Bus address |
| wb_dato | output | 32 | Bus write data |
| wb_dati | input | 32 | Bus read data |
| wb_ack | input | 1 | Bus acknowledge |
| wb_err | input | 1 | Bus error |
| cpu_stb | output | 1 | Processor access strobe |
| cpu_we | output | 1 | Processor write enable |
| cpu_addr | output | 32 | Processor register address |
| cpu_wdata | output | 32 | Processor write data |
| cpu_rdata | input | 32 | Processor read data |
| cfg_regs | output | 160 | Register bank contents |

## Verification
The bench targets frames that must be dropped: a flipped check bit, one bit too few, one bit too many, and chain code 3. A design that launched any of them would change `cfg_regs`, bump the bus or processor transaction count, or alter the next return word.

It also follows the deferred-return rule on every frame. A design that returned data in the same frame, or that did not clear the data for writes and errors, would show a wrong word on `tdo` one frame later.

Unmapped register addresses, read frames with non-zero data bits, random bus wait states and slave errors round out the list. These catch address aliasing, writes on reads, a bus cycle dropped before ack, and error results carrying stale data.

// File: rtl/jdf_pkg.sv
package jdf_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;
    localparam int REG_AW = 5;
    localparam int CRC_W  = 8;
    localparam int NREG   = 5;

    typedef enum logic [1:0] {
        CH_REG  = 2'd0,
        CH_CPU  = 2'd1,
        CH_BUS  = 2'd2,
        CH_NONE = 2'd3
    } chain_e;

    typedef struct packed {
        chain_e              chain;
        logic                we;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
    } acc_req_t;

    typedef struct packed {
        logic                bad;
        logic                err;
        logic [DATA_W-1:0]   data;
    } ret_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REG,
        S_CPU,
        S_CPU_CAP,
        S_BUS,
        S_DONE
    } state_e;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                   input logic b,
                                                   input logic [CRC_W-1:0] poly);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    endfunction

endpackage

// File: rtl/jdf_sync.sv
module jdf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/jdf_frame.sv
module jdf_frame import jdf_pkg::*; #(
    parameter logic [CRC_W-1:0] POLY = 8'h07
) (
    input  logic     tck,
    input  logic     trst_n,
    input  logic     capture_dr,
    input  logic     shift_dr,
    input  logic     update_dr,
    input  logic     tdi,
    input  chain_e   chain,
    input  logic     busy,
    input  ret_t     ret_word,
    output logic     tdo,
    output acc_req_t req,
    output logic     req_tgl
);
    localparam int FRAME_MAX = ADDR_W + 1 + DATA_W + CRC_W;
    localparam int CNT_W     = $clog2(FRAME_MAX + 2);
    localparam int RET_W     = $bits(ret_t);
    localparam int AIDX_W    = $clog2(ADDR_W);
    localparam int DIDX_W    = $clog2(DATA_W);
    localparam int CIDX_W    = $clog2(CRC_W);

    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  aw, data_end, len, d_off, c_off;
    logic [ADDR_W-1:0] f_addr;
    logic              f_we;
    logic [DATA_W-1:0] f_data;
    logic [CRC_W-1:0]  f_crc_rx, crc_calc;
    logic [RET_W-1:0]  out_sr;
    logic              frame_ok;

    always_comb begin
        aw       = (chain == CH_REG) ? CNT_W'(REG_AW) : CNT_W'(ADDR_W);
        data_end = aw + CNT_W'(1 + DATA_W);
        len      = data_end + CNT_W'(CRC_W);
        d_off    = cnt - aw - CNT_W'(1);
        c_off    = cnt - data_end;
        frame_ok = (cnt == len) && (f_crc_rx == crc_calc) && !busy && (chain != CH_NONE);
    end

    // Field assembly and return shifter
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            cnt      <= '0;
            f_addr   <= '0;
            f_we     <= 1'b0;
            f_data   <= '0;
            f_crc_rx <= '0;
            crc_calc <= '0;
            out_sr   <= '0;
        end else if (capture_dr) begin
            cnt      <= '0;
            f_addr   <= '0;
            f_we     <= 1'b0;
            f_data   <= '0;
            f_crc_rx <= '0;
            crc_calc <= '0;
            out_sr   <= ret_word;
        end else if (shift_dr) begin
            out_sr <= {1'b0, out_sr[RET_W-1:1]};
            if (cnt != '1) cnt <= cnt + CNT_W'(1);
            if (cnt < aw)            f_addr[cnt[AIDX_W-1:0]]     <= tdi;
            else if (cnt == aw)      f_we                        <= tdi;
            else if (cnt < data_end) f_data[d_off[DIDX_W-1:0]]   <= tdi;
            else if (cnt < len)      f_crc_rx[c_off[CIDX_W-1:0]] <= tdi;
            if (cnt < data_end) crc_calc <= crc_step(crc_calc, tdi, POLY);
        end
    end

    // Launch on a clean update
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            req     <= '0;
            req_tgl <= 1'b0;
        end else if (update_dr && frame_ok) begin
            req.chain <= chain;
            req.we    <= f_we;
            req.addr  <= f_addr;
            req.data  <= f_data;
            req_tgl   <= ~req_tgl;
        end
    end

    assign tdo = out_sr[0];
endmodule

// File: rtl/jdf_regs.sv
module jdf_regs #(
    parameter int NUM = 5,
    parameter int DW  = 32,
    parameter int AW  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              hit,
    output logic [NUM*DW-1:0] regs_flat
);
    logic [DW-1:0] bank [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            bank[g] <= '0;
            else if (wr_en && addr == AW'(g))      bank[g] <= wdata;
        end
        assign regs_flat[g*DW +: DW] = bank[g];
    end

    always_comb begin
        rdata = '0;
        hit   = 1'b0;
        for (int i = 0; i < NUM; i++) begin
            if (addr == AW'(i)) begin
                rdata = bank[i];
                hit   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/jdf_access.sv
module jdf_access import jdf_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_tgl_s,
    input  acc_req_t          req,
    output logic              ack_tgl,
    output ret_t              ret,
    output logic              reg_wr,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              reg_hit,
    output logic              cpu_stb,
    output logic              cpu_we,
    output logic [ADDR_W-1:0] cpu_addr,
    output logic [DATA_W-1:0] cpu_wdata,
    input  logic [DATA_W-1:0] cpu_rdata,
    output logic              wb_cyc,
    output logic              wb_stb,
    output logic              wb_we,
    output logic [3:0]        wb_sel,
    output logic [ADDR_W-1:0] wb_adr,
    output logic [DATA_W-1:0] wb_dato,
    input  logic [DATA_W-1:0] wb_dati,
    input  logic              wb_ack,
    input  logic              wb_err
);
    state_e state_q, state_d;
    logic   req_seen;
    logic   start;

    assign start = (req_tgl_s != req_seen);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    unique case (req.chain)
                        CH_REG:  state_d = S_REG;
                        CH_CPU:  state_d = S_CPU;
                        CH_BUS:  state_d = S_BUS;
                        CH_NONE: state_d = S_DONE;
                    endcase
                end
            end
            S_REG:     state_d = S_DONE;
            S_CPU:     state_d = req.we ? S_DONE : S_CPU_CAP;
            S_CPU_CAP: state_d = S_DONE;
            S_BUS:     state_d = (wb_ack || wb_err) ? S_DONE : S_BUS;
            S_DONE:    state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cpu_stb   = (state_q == S_CPU);
        cpu_we    = (state_q == S_CPU) && req.we;
        cpu_addr  = req.addr;
        cpu_wdata = req.data;
        wb_cyc    = (state_q == S_BUS);
        wb_stb    = (state_q == S_BUS);
        wb_we     = (state_q == S_BUS) && req.we;
        wb_sel    = (state_q == S_BUS) ? 4'hF : 4'h0;
        wb_adr    = req.addr;
        wb_dato   = req.data;
        reg_wr    = (state_q == S_REG) && req.we && reg_hit;
    end

    // Result capture and handshake
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_seen <= 1'b0;
            ack_tgl  <= 1'b0;
            ret      <= '0;
        end else begin
            if (state_q == S_IDLE && start) req_seen <= req_tgl_s;
            if (state_q == S_DONE) ack_tgl <= ~ack_tgl;
            if (state_q == S_REG) begin
                ret.bad  <= !reg_hit;
                ret.err  <= 1'b0;
                ret.data <= (reg_hit && !req.we) ? reg_rdata : '0;
            end
            if (state_q == S_CPU && req.we) ret <= '0;
            if (state_q == S_CPU_CAP) begin
                ret.bad  <= 1'b0;
                ret.err  <= 1'b0;
                ret.data <= cpu_rdata;
            end
            if (state_q == S_BUS && (wb_ack || wb_err)) begin
                ret.bad  <= 1'b0;
                ret.err  <= wb_err;
                ret.data <= (!wb_err && !req.we) ? wb_dati : '0;
            end
        end
    end
endmodule

// File: rtl/jdf_top.sv
module jdf_top import jdf_pkg::*; #(
    parameter int               SYNC_STAGES = 2,
    parameter int               NUM_REGS    = NREG,
    parameter logic [CRC_W-1:0] CRC_POLY    = 8'h07
) (
    input  logic                       tck,
    input  logic                       trst_n,
    input  logic                       capture_dr,
    input  logic                       shift_dr,
    input  logic                       update_dr,
    input  logic                       tdi,
    input  logic [1:0]                 chain_sel,
    output logic                       tdo,
    input  logic                       sys_clk,
    input  logic                       sys_rst_n,
    output logic                       wb_cyc,
    output logic                       wb_stb,
    output logic                       wb_we,
    output logic [3:0]                 wb_sel,
    output logic [ADDR_W-1:0]          wb_adr,
    output logic [DATA_W-1:0]          wb_dato,
    input  logic [DATA_W-1:0]          wb_dati,
    input  logic                       wb_ack,
    input  logic                       wb_err,
    output logic                       cpu_stb,
    output logic                       cpu_we,
    output logic [ADDR_W-1:0]          cpu_addr,
    output logic [DATA_W-1:0]          cpu_wdata,
    input  logic [DATA_W-1:0]          cpu_rdata,
    output logic [NUM_REGS*DATA_W-1:0] cfg_regs
);
    acc_req_t          req;
    ret_t              ret_w;
    logic              req_tgl, req_tgl_s, ack_tgl, ack_tgl_t, busy;
    logic              reg_wr, reg_hit;
    logic [DATA_W-1:0] reg_rdata;

    assign busy = req_tgl ^ ack_tgl_t;

    jdf_frame #(.POLY(CRC_POLY)) u_frame (
        .tck(tck), .trst_n(trst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .tdi(tdi), .chain(chain_e'(chain_sel)), .busy(busy),
        .ret_word(ret_w), .tdo(tdo), .req(req), .req_tgl(req_tgl)
    );

    jdf_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(sys_clk), .rst_n(sys_rst_n), .d(req_tgl), .q(req_tgl_s)
    );

    jdf_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(tck), .rst_n(trst_n), .d(ack_tgl), .q(ack_tgl_t)
    );

    jdf_access u_acc (
        .clk(sys_clk), .rst_n(sys_rst_n), .req_tgl_s(req_tgl_s), .req(req),
        .ack_tgl(ack_tgl), .ret(ret_w), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
        .reg_hit(reg_hit), .cpu_stb(cpu_stb), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
        .wb_we(wb_we), .wb_sel(wb_sel), .wb_adr(wb_adr), .wb_dato(wb_dato),
        .wb_dati(wb_dati), .wb_ack(wb_ack), .wb_err(wb_err)
    );

    jdf_regs #(.NUM(NUM_REGS), .DW(DATA_W), .AW(REG_AW)) u_regs (
        .clk(sys_clk), .rst_n(sys_rst_n), .wr_en(reg_wr), .addr(req.addr[REG_AW-1:0]),
        .wdata(req.data), .rdata(reg_rdata), .hit(reg_hit), .regs_flat(cfg_regs)
    );
endmodule

// File: rtl/jdf_checker.sv
module jdf_checker (
    input logic        sys_clk,
    input logic        sys_rst_n,
    input logic        tck,
    input logic        trst_n,
    input logic        update_dr,
    input logic        req_tgl,
    input logic        wb_cyc,
    input logic        wb_we,
    input logic [31:0] wb_adr,
    input logic [31:0] wb_dato,
    input logic        wb_ack,
    input logic        wb_err,
    input logic        cpu_stb,
    input logic [33:0] ret_word
);
    // R1: a launch toggle only ever follows an update strobe
    a_r1_launch_on_update: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(req_tgl) |-> $past(update_dr));

    // R7: bus request held stable while waiting
    a_r7_bus_hold: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (wb_cyc && !wb_ack && !wb_err) |=> (wb_cyc && $stable(wb_adr) && $stable(wb_we) && $stable(wb_dato)));

    // R7: cycle released right after termination
    a_r7_bus_release: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (wb_cyc && (wb_ack || wb_err)) |=> !wb_cyc);

    // R10: one-cycle processor strobe
    a_r10_cpu_pulse: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        cpu_stb |=> !cpu_stb);

    // R10: processor and bus never active together
    a_r10_exclusive: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        !(cpu_stb && wb_cyc));

    // R9: error result carries no data
    a_r9_err_zero: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        ret_word[32] |-> (ret_word[31:0] == 32'h0 && !ret_word[33]));

    // R4: bad-address result carries no data
    a_r4_bad_zero: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        ret_word[33] |-> (ret_word[31:0] == 32'h0 && !ret_word[32]));
endmodule

bind jdf_top jdf_checker u_chk (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .tck(tck), .trst_n(trst_n),
    .update_dr(update_dr), .req_tgl(req_tgl), .wb_cyc(wb_cyc), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_dato(wb_dato), .wb_ack(wb_ack), .wb_err(wb_err),
    .cpu_stb(cpu_stb), .ret_word(ret_w)
);

// File: tb/sim_jdf_top.sv
`timescale 1ns/1ps
module sim_jdf_top;
    localparam logic [31:0] K_CPU = 32'hC3C3_0F0F;
    localparam logic [31:0] K_BUS = 32'h5A5A_1234;

    logic tck = 0, trst_n = 0, capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
    logic [1:0] chain_sel = 0;
    logic tdo;
    logic sys_clk = 0, sys_rst_n = 0;
    logic wb_cyc, wb_stb, wb_we;
    logic [3:0] wb_sel;
    logic [31:0] wb_adr, wb_dato, wb_dati = 0;
    logic wb_ack = 0, wb_err = 0;
    logic cpu_stb, cpu_we;
    logic [31:0] cpu_addr, cpu_wdata, cpu_rdata = 0;
    logic [159:0] cfg_regs;

    always #2 sys_clk = ~sys_clk;
    always #20 tck = ~tck;

    jdf_top u0 (.*);

    int checks = 0, errors = 0;
    bit done = 0;

    // bus slave model with random waits
    int unsigned bus_count = 0, wait_left = 0;
    bit slv_act = 0;
    logic [31:0] b_adr, b_dat;
    logic b_we;
    logic [3:0] b_sel;
    always @(posedge sys_clk) begin
        wb_ack <= 1'b0;
        wb_err <= 1'b0;
        if (wb_cyc && wb_stb && !wb_ack && !wb_err) begin
            if (!slv_act) begin
                slv_act = 1;
                wait_left = $urandom_range(0, 4);
            end
            if (wait_left == 0) begin
                slv_act = 0;
                bus_count++;
                b_adr = wb_adr; b_dat = wb_dato; b_we = wb_we; b_sel = wb_sel;
                if (wb_adr[31:28] == 4'hE) wb_err <= 1'b1;
                else begin
                    wb_ack  <= 1'b1;
                    wb_dati <= wb_adr ^ K_BUS;
                end
            end else wait_left--;
        end
    end

    // processor port model
    int unsigned cpu_count = 0;
    logic [31:0] c_adr, c_dat;
    logic c_we;
    always @(posedge sys_clk) begin
        if (cpu_stb) begin
            cpu_count++;
            c_adr = cpu_addr; c_dat = cpu_wdata; c_we = cpu_we;
            if (!cpu_we) cpu_rdata <= cpu_addr ^ K_CPU;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] crc8(input logic [7:0] c, input logic b);
        logic fb;
        fb = c[7] ^ b;
        return {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    endfunction

    // reference state
    logic [31:0] ref_regs [5];
    logic [33:0] exp_ret = 0;
    int unsigned bus_exp = 0, cpu_exp = 0;

    task automatic run_frame(input logic [1:0] ch, input logic [31:0] addr, input logic we,
                             input logic [31:0] data, input int len_adj, input bit bad_crc,
                             output logic [33:0] got);
        logic [79:0] bits;
        logic [7:0] c;
        int aw, n, len;
        bits = '0; c = 0; n = 0;
        aw = (ch == 2'd0) ? 5 : 32;
        for (int i = 0; i < aw; i++) begin bits[n] = addr[i]; c = crc8(c, addr[i]); n++; end
        bits[n] = we; c = crc8(c, we); n++;
        for (int i = 0; i < 32; i++) begin bits[n] = data[i]; c = crc8(c, data[i]); n++; end
        for (int i = 0; i < 8; i++) begin bits[n] = c[i] ^ ((bad_crc && i == 0) ? 1'b1 : 1'b0); n++; end
        len = aw + 41 + len_adj;
        got = '0;
        @(negedge tck);
        chain_sel = ch;
        capture_dr = 1;
        @(negedge tck);
        capture_dr = 0;
        shift_dr = 1;
        for (int i = 0; i < len; i++) begin
            tdi = bits[i];
            if (i < 34) got[i] = tdo;
            @(negedge tck);
        end
        shift_dr = 0;
        update_dr = 1;
        @(negedge tck);
        update_dr = 0;
        tdi = 0;
        repeat (12) @(negedge tck);
    endtask

    task automatic do_access(input string tag, input logic [1:0] ch, input logic [31:0] addr_in,
                             input logic we, input logic [31:0] data, input int len_adj, input bit bad_crc);
        logic [33:0] got;
        logic [31:0] addr;
        bit valid;
        addr = (ch == 2'd0) ? (addr_in & 32'h1F) : addr_in;
        run_frame(ch, addr, we, data, len_adj, bad_crc, got);
        chk({tag, " R2 return word of previous access"}, 64'(got), 64'(exp_ret));
        valid = (len_adj == 0) && !bad_crc && (ch != 2'd3);
        if (valid) begin
            case (ch)
                2'd0: begin
                    if (addr < 5) begin
                        if (we) begin ref_regs[addr] = data; exp_ret = '0; end
                        else exp_ret = {2'b00, ref_regs[addr]};
                    end else exp_ret = {2'b10, 32'h0};
                end
                2'd1: begin
                    cpu_exp++;
                    exp_ret = we ? 34'h0 : {2'b00, addr ^ K_CPU};
                end
                default: begin
                    bus_exp++;
                    if (addr[31:28] == 4'hE) exp_ret = {2'b01, 32'h0};
                    else exp_ret = we ? 34'h0 : {2'b00, addr ^ K_BUS};
                end
            endcase
        end
        for (int r = 0; r < 5; r++)
            chk({tag, " R3/R4/R11 register bank"}, 64'(cfg_regs[r*32 +: 32]), 64'(ref_regs[r]));
        chk({tag, " R7 bus transfer count"}, 64'(bus_count), 64'(bus_exp));
        chk({tag, " R10 processor access count"}, 64'(cpu_count), 64'(cpu_exp));
        if (valid && ch == 2'd2) begin
            chk({tag, " R7 bus address"}, 64'(b_adr), 64'(addr));
            chk({tag, " R7 bus we/sel"}, 64'({b_we, b_sel}), 64'({we, 4'hF}));
            if (we) chk({tag, " R7 bus write data"}, 64'(b_dat), 64'(data));
        end
        if (valid && ch == 2'd1) begin
            chk({tag, " R10 processor address"}, 64'(c_adr), 64'(addr));
            chk({tag, " R10 processor we"}, 64'(c_we), 64'(we));
            if (we) chk({tag, " R10 processor write data"}, 64'(c_dat), 64'(data));
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #700000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int r = 0; r < 5; r++) ref_regs[r] = 0;
        #100;
        trst_n = 1;
        sys_rst_n = 1;
        @(negedge tck);
        chk("R2 tdo after reset", 64'(tdo), 64'h0);
        chk("R3 bank after reset", 64'(cfg_regs[63:0]), 64'h0);
        chk("R7 no bus cycle after reset", 64'(wb_cyc), 64'h0);

        // R3: each mapped register
        for (int a = 0; a < 5; a++)
            do_access("R3 write", 2'd0, 32'(a), 1'b1, $urandom(), 0, 0);
        do_access("R2 read reg 2", 2'd0, 32'd2, 1'b0, 32'h0, 0, 0);
        // R11: read frame with non-zero data bits
        do_access("R11 read with data", 2'd0, 32'd4, 1'b0, 32'hFFFF_FFFF, 0, 0);
        // R4: unmapped
        do_access("R4 read 0x1F", 2'd0, 32'h1F, 1'b0, 32'h0, 0, 0);
        do_access("R4 write 0x07", 2'd0, 32'h07, 1'b1, 32'hDEAD_BEEF, 0, 0);
        do_access("R4 write 0x05", 2'd0, 32'h05, 1'b1, 32'h1234_5678, 0, 0);
        // R5: check code mismatch on each chain
        do_access("R5 bad crc reg", 2'd0, 32'd1, 1'b1, 32'hAAAA_5555, 0, 1);
        do_access("R5 bad crc bus", 2'd2, 32'h1000_0040, 1'b1, 32'h1, 0, 1);
        do_access("R5 bad crc cpu", 2'd1, 32'h0000_2001, 1'b1, 32'h2, 0, 1);
        // R6: wrong length
        do_access("R6 short frame", 2'd0, 32'd0, 1'b1, 32'h0BAD_0BAD, -1, 0);
        do_access("R6 long frame", 2'd2, 32'h1000_0080, 1'b1, 32'h0BAD_0BAD, 1, 0);
        // R1: chain code 3
        do_access("R1 chain 3", 2'd3, 32'h1000_0000, 1'b1, 32'h5, 0, 0);
        // R8/R9/R10 directed
        do_access("R8 bus read", 2'd2, 32'h1234_5678, 1'b0, 32'h0, 0, 0);
        do_access("R9 bus error", 2'd2, 32'hE000_0010, 1'b0, 32'h0, 0, 0);
        do_access("R7 bus write", 2'd2, 32'h2000_0004, 1'b1, 32'hCAFE_F00D, 0, 0);
        do_access("R10 cpu read", 2'd1, 32'h0000_1801, 1'b0, 32'h0, 0, 0);
        do_access("R10 cpu write", 2'd1, 32'h0000_1802, 1'b1, 32'h7777_1111, 0, 0);
        do_access("R1 reg read", 2'd0, 32'd0, 1'b0, 32'h0, 0, 0);

        // constrained random traffic
        for (int k = 0; k < 40; k++) begin
            logic [1:0] ch;
            logic [31:0] a;
            ch = 2'($urandom_range(0, 2));
            if (ch == 2'd0) a = ($urandom_range(0, 3) == 0) ? 32'($urandom_range(5, 31)) : 32'($urandom_range(0, 4));
            else if (ch == 2'd2) a = {(($urandom_range(0, 3) == 0) ? 4'hE : 4'h3), 28'($urandom())};
            else a = $urandom();
            do_access("R1 random", ch, a, 1'($urandom_range(0, 1)), $urandom(), 0, 0);
        end
        // flush the last return word
        do_access("R2 final", 2'd0, 32'd3, 1'b0, 32'h0, 0, 0);
        finish_run();
    end
endmodule